// File: doc/BRIEF.md
# Padded Rate-1/2 Packet Convolutional Encoder

This transmit-side block takes the protected part of one packet (payload plus checksum) as a byte stream. A start marker and a last-byte marker frame the packet, a valid/ready pair paces it, and a length value comes with the start byte. In encode mode the block appends zero-valued trailer bytes. The trailer makes the protected length even, so it fills whole two-byte interleaver blocks, and it drives the code trellis back to the all-zero state. Every bit, most significant first, then passes through a rate one-half convolutional coder with constraint length 4, which produces one coded bit pair per cycle.

A packet whose declared length is below two bytes cannot be interleaved, so the block refuses it in encode mode. It consumes the bytes, emits nothing and raises a one-cycle error pulse. When the enable is low at the start byte, the packet goes through uncoded at one plain bit per cycle, with no trailer and no length check.

Top module: `conv_pad_encoder`

## Requirements
- R1: After reset `out_valid` and `err_short` are 0 and `in_ready` is 1.
- R2: In encode mode each byte of the packet and of the trailer yields exactly 8 coded pairs, one per cycle with `out_valid` high.
- R3: With b the current bit and p1, p2, p3 the previous one, two and three bits, `out_bits[1]` = b^p1^p3 and `out_bits[0]` = b^p1^p2^p3. Bits are taken most significant first.
- R4: The coder history (p1..p3) is zero for the first bit of every packet, whatever the previous packet left in it.
- R5: In encode mode an odd `pkt_len` adds one trailer byte and an even `pkt_len` adds two, so at least one is always added.
- R6: Trailer bytes are 0x00, so the last coded pair of an encoded packet is 2'b00 and the coder ends in the zero state.
- R7: With `enc_en` high and `pkt_len` below 2 at the start byte, `err_short` pulses high for one cycle, on the cycle after that byte is accepted. All bytes up to the last-byte marker are accepted and dropped, and no output is produced.
- R8: With `enc_en` low at the start byte, each bit is output as `out_bits` = {bit, 1'b0}. No trailer is added and no length is refused.
- R9: `in_ready` is low while a byte is being shifted, except on its last bit when no trailer is pending. Bytes offered back to back therefore give an output with no gaps.
- R10: Idle cycles between bytes of a packet leave the coder history unchanged, so the coded stream does not depend on input gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_en | input | 1 | Encode mode select, sampled with the start byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| pkt_len | input | 8 | Protected length in bytes, sampled with the start byte |
| out_valid | output | 1 | Output pair valid |
| out_bits | output | 2 | Coded pair (bit 1 from the first generator), or {plain bit, 0} in bypass |
| err_short | output | 1 | One-cycle pulse when a too-short packet is refused |

## Verification
The assertions check on every cycle that the input is never ready in the middle of a byte's output, that the coder history is zero after a start byte is loaded, that an error pulse follows only a refused short start byte and never comes with output, and that bypass output keeps its low bit at zero. Only the bench's scenarios can show that the coded values, the trailer count, the final return to zero and the independence from input gaps are right, because each of these needs the whole packet compared against a reference coder. The bench runs random packets with random gaps and random modes, and adds directed packets at the shortest legal lengths, refused packets and a one-byte bypass packet.

// File: rtl/conv_pad_encoder.sv
module conv_pad_encoder #(
  parameter int DW    = 8,
  parameter int LEN_W = 8,
  parameter int K     = 4,
  parameter logic [K-1:0] G_A = 4'b1101,
  parameter logic [K-1:0] G_B = 4'b1111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             out_valid,
  output logic [1:0]       out_bits,
  output logic             err_short
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;

  logic          busy, mode, par, drop;
  logic [DW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [1:0]    pads;
  logic [K-2:0]  st;

  wire          last_bit = (cnt == CW'(DW - 1));
  wire          fire     = in_valid & in_ready;
  wire          short    = enc_en & (pkt_len < LEN_W'(2));
  wire          refuse   = fire & in_sop & short & ~drop;
  wire          load     = fire & ~drop & ~refuse;
  wire [K-1:0]  win      = {sh[DW-1], st};
  wire          c_a      = ^(win & G_A);
  wire          c_b      = ^(win & G_B);
  wire          enc_now  = in_sop ? enc_en : mode;
  wire          par_now  = in_sop ? pkt_len[0] : par;

  assign in_ready  = drop | ~busy | (last_bit & (pads == 2'd0));
  assign out_valid = busy;
  assign out_bits  = mode ? {c_a, c_b} : {sh[DW-1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      mode      <= 1'b0;
      par       <= 1'b0;
      drop      <= 1'b0;
      sh        <= '0;
      cnt       <= '0;
      pads      <= 2'd0;
      st        <= '0;
      err_short <= 1'b0;
    end else begin
      err_short <= refuse;

      if (refuse && !in_eop)
        drop <= 1'b1;
      else if (drop && fire && in_eop)
        drop <= 1'b0;

      if (busy) begin
        sh  <= sh << 1;
        cnt <= cnt + CW'(1);
        if (mode) st <= win[K-1:1];
      end

      if (busy && last_bit) begin
        cnt <= '0;
        if (pads != 2'd0) begin
          sh   <= '0;
          pads <= pads - 2'd1;
        end else if (!load) begin
          busy <= 1'b0;
        end
      end

      if (load) begin
        sh   <= in_data;
        cnt  <= '0;
        busy <= 1'b1;
        if (in_sop) begin
          st   <= '0;
          mode <= enc_en;
          par  <= pkt_len[0];
        end
        if (in_eop)
          pads <= enc_now ? (par_now ? 2'd1 : 2'd2) : 2'd0;
      end
    end
  end
endmodule

module conv_pad_encoder_chk #(
  parameter int DW    = 8,
  parameter int LEN_W = 8,
  parameter int K     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sop,
  input logic [LEN_W-1:0] pkt_len,
  input logic             out_valid,
  input logic [1:0]       out_bits,
  input logic             err_short,
  input logic             mode,
  input logic             drop,
  input logic [K-2:0]     st
);
  localparam int VW = (DW > 1) ? $clog2(DW) : 1;
  logic [VW-1:0] vcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) vcnt <= '0;
    else if (out_valid) vcnt <= (vcnt == VW'(DW - 1)) ? '0 : vcnt + VW'(1);
  end

  // R9
  midbyte_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && vcnt != VW'(DW - 1)) |-> !in_ready);

  // R4
  sop_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sop && !drop && !(enc_en && pkt_len < LEN_W'(2))) |=> (st == '0));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |-> $past(in_valid && in_ready && in_sop && enc_en && pkt_len < LEN_W'(2)));

  // R7
  err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_short |-> !out_valid);

  // R8
  bypass_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mode) |-> (out_bits[0] == 1'b0));
endmodule

bind conv_pad_encoder conv_pad_encoder_chk #(.DW(DW), .LEN_W(LEN_W), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .in_valid(in_valid), .in_ready(in_ready),
  .in_sop(in_sop), .pkt_len(pkt_len), .out_valid(out_valid), .out_bits(out_bits),
  .err_short(err_short), .mode(mode), .drop(drop), .st(st)
);

// File: tb/test_conv_pad_encoder.sv
module test_conv_pad_encoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_en = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic [7:0] pkt_len = '0;
  logic       out_valid;
  logic [1:0] out_bits;
  logic       err_short;

  conv_pad_encoder i_conv_pad_encoder (
    .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .pkt_len(pkt_len),
    .out_valid(out_valid), .out_bits(out_bits), .err_short(err_short)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, err_seen = 0, cyc = 0, first_t = 0, last_t = 0;
  logic [1:0] got[$];
  logic [1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (out_valid) begin
        if (got.size() == 0) first_t = cyc;
        last_t = cyc;
        got.push_back(out_bits);
      end
      if (err_short) err_seen++;
    end
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic void add_exp(input logic [7:0] d[$], input bit en, input int len);
    logic [7:0] all[$];
    logic p1, p2, p3, x;
    all = d;
    p1 = 0; p2 = 0; p3 = 0;
    if (en) begin
      all.push_back(8'h00);
      if (len % 2 == 0) all.push_back(8'h00);
    end
    foreach (all[i]) begin
      for (int b = 7; b >= 0; b--) begin
        x = all[i][b];
        if (en) begin
          exp_q.push_back({x ^ p1 ^ p3, x ^ p1 ^ p2 ^ p3});
          p3 = p2; p2 = p1; p1 = x;
        end else begin
          exp_q.push_back({x, 1'b0});
        end
      end
    end
  endfunction

  task automatic send(input logic [7:0] d[$], input int len, input bit en, input bit gaps);
    for (int i = 0; i < d.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d[i]; in_sop = (i == 0); in_eop = (i == d.size() - 1);
      pkt_len = 8'(len); enc_en = en;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      if (gaps && $urandom_range(0, 3) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat ($urandom_range(1, 12)) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic run_pkt(input logic [7:0] d[$], input bit en, input bit gaps, input string tag);
    got.delete(); exp_q.delete();
    add_exp(d, en, d.size());
    send(d, d.size(), en, gaps);
    repeat (40) @(negedge clk);
    chk(got.size() == exp_q.size(), {tag, " R2 R5 pair count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], {tag, " R3 R4 R10 coded pair"}, got[i], exp_q[i]);
    if (en && got.size() > 0)
      chk(got[got.size() - 1] == 2'b00, {tag, " R6 final pair"}, got[got.size() - 1], 0);
    if (!gaps && got.size() > 0)
      chk(last_t - first_t + 1 == got.size(), {tag, " R9 gap-free output"}, last_t - first_t + 1, got.size());
  endtask

  initial begin
    logic [7:0] d[$];
    int e0;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(err_short == 1'b0, "R1 err_short", err_short, 0);

    d = '{8'hA5, 8'h3C};
    run_pkt(d, 1'b1, 1'b0, "two-byte even");
    d = '{8'hFF, 8'h01, 8'h80};
    run_pkt(d, 1'b1, 1'b0, "three-byte odd");
    d = '{8'hFF, 8'hFF};
    run_pkt(d, 1'b1, 1'b1, "R4 after ones");

    e0 = err_seen; got.delete();
    d = '{8'h5A};
    send(d, 1, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk(err_seen == e0 + 1, "R7 error pulse", err_seen - e0, 1);
    chk(got.size() == 0, "R7 no output", got.size(), 0);

    e0 = err_seen; got.delete();
    d = '{8'h11, 8'h22, 8'h33};
    send(d, 0, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(err_seen == e0 + 1, "R7 multi-byte error pulse", err_seen - e0, 1);
    chk(got.size() == 0, "R7 multi-byte dropped", got.size(), 0);
    chk(in_ready == 1'b1, "R7 ready after drop", in_ready, 1);

    d = '{8'hC3};
    run_pkt(d, 1'b0, 1'b0, "R8 one-byte bypass");
    d = '{8'h96, 8'h0F, 8'hE1, 8'h42};
    run_pkt(d, 1'b0, 1'b1, "R8 bypass gaps");

    for (int p = 0; p < 40; p++) begin
      int n;
      bit en, gp;
      n = $urandom_range(2, 20);
      en = ($urandom_range(0, 3) != 0);
      gp = $urandom_range(0, 1);
      d.delete();
      for (int i = 0; i < n; i++) d.push_back(8'($urandom));
      run_pkt(d, en, gp, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule